// File: doc/BRIEF.md
# Program-Counter Sequencer with Branch and Jump Resolution

This block holds the program counter of a simple in-order processor and chooses the address of the next instruction every cycle. It looks at the instruction currently fetched and at the two source register values the register file supplies. From these it picks one of five continuations: fall through to the next word, take a PC-relative conditional branch on equality or inequality, jump to an absolute region address, jump and record a return address, or jump to an address held in a register.

The PC is one register with synchronous reset to a parameterised vector and a stall input that freezes it. The chosen next address is visible combinationally on `npc_o` and is loaded into the PC at the next rising clock edge. For the jump-and-link case the block also presents a write request for the link register, together with its index and the return address, in the same cycle the instruction is accepted. A surrounding pipeline connects `instr_i` to instruction memory, `rs_val_i`/`rt_val_i` to the register file read ports, and the link outputs to a register file write port.

Top module: `pc_flow_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge the PC is loaded with parameter `RESET_VEC` (default 0x0040_0000), which `pc_o` shows from the following cycle.
- R2: While `stall_i` is high at a rising edge the PC keeps its value, and `link_we_o` stays low whatever the instruction.
- R3: An instruction whose opcode (bits 31:26) is none of 2, 3, 4, 5, or whose opcode is 0 with function field (bits 5:0) other than 0x08, advances the PC to PC+4.
- R4: Opcode 4 takes the branch when `rs_val_i` equals `rt_val_i`: the next PC is PC+4 plus four times the signed 16-bit value in bits 15:0. Otherwise the next PC is PC+4.
- R5: Opcode 5 takes the same branch target when `rs_val_i` differs from `rt_val_i`, and falls through to PC+4 when they are equal.
- R6: Opcode 2 jumps to an address whose top four bits come from PC+4, whose next 26 bits are instruction bits 25:0, and whose low two bits are zero.
- R7: Opcode 3 jumps exactly as in R6 and, in a cycle with neither reset nor stall, drives `link_we_o` high with `link_idx_o` = 31 and `link_data_o` = PC+8.
- R8: Opcode 0 with function field 0x08 loads the PC with `rs_val_i` unchanged.
- R9: `link_we_o` is low for every instruction other than opcode 3, and also low while `rst` is high.
- R10: All address arithmetic wraps modulo 2^32, so PC+4 from 0xFFFF_FFFC is 0 and backward branches below address 0 wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, high active |
| stall_i | input | 1 | Freezes the PC and suppresses the link write |
| instr_i | input | 32 | Instruction at the current PC |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Next program counter selected this cycle |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Register index for the link write (31) |
| link_data_o | output | 32 | Return address PC+8 |

## Verification
The link request, its index and data are combinational in the instruction and stall inputs, so they are due in the same cycle and the bench samples them one nanosecond after driving the inputs at a falling edge. Every PC result passes through one register and is due one rising edge later; the bench applies the instruction, waits for that edge and the next falling edge, then compares `pc_o`. Arbitrary start addresses are reached by a register-indirect jump in the preceding cycle, and the expected targets are computed as plain integer sums and masks in the bench.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int unsigned INSTR_W = 32;

   localparam logic [5:0] OPC_SPECIAL  = 6'd0;
   localparam logic [5:0] OPC_JUMP     = 6'd2;
   localparam logic [5:0] OPC_JUMPLINK = 6'd3;
   localparam logic [5:0] OPC_BR_EQ    = 6'd4;
   localparam logic [5:0] OPC_BR_NE    = 6'd5;
   localparam logic [5:0] FN_JUMPREG   = 6'h08;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BR_EQ,
      FLOW_BR_NE,
      FLOW_JUMP,
      FLOW_JLINK,
      FLOW_JREG
   } flow_e;

   function automatic logic [5:0] opc_of(input logic [INSTR_W-1:0] ins);
      return ins[31:26];
   endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   output flow_e              flow_o,
   output logic [15:0]        imm_o,
   output logic [25:0]        jfield_o
);
   logic [5:0] opc;
   logic [5:0] fn;

   assign opc      = opc_of(instr_i);
   assign fn       = instr_i[5:0];
   assign imm_o    = instr_i[15:0];
   assign jfield_o = instr_i[25:0];

   always_comb begin
      flow_o = FLOW_SEQ;
      case (opc)
         OPC_SPECIAL:  if (fn == FN_JUMPREG) flow_o = FLOW_JREG;
         OPC_JUMP:     flow_o = FLOW_JUMP;
         OPC_JUMPLINK: flow_o = FLOW_JLINK;
         OPC_BR_EQ:    flow_o = FLOW_BR_EQ;
         OPC_BR_NE:    flow_o = FLOW_BR_NE;
         default:      flow_o = FLOW_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_compare.sv
module npc_compare #(
   parameter int unsigned XLEN    = 32,
   parameter bit          XOR_CMP = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o
);
   if (XLEN < 1) begin : g_bad_w
      $error("npc_compare: XLEN must be positive");
   end

   if (XOR_CMP) begin : g_xor
      logic [XLEN-1:0] diff;
      assign diff = a_i ^ b_i;
      assign eq_o = ~(|diff);
   end else begin : g_eq
      assign eq_o = (a_i == b_i);
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] pc_i,
   input  flow_e           flow_i,
   input  logic            eq_i,
   input  logic [15:0]     imm_i,
   input  logic [25:0]     jfield_i,
   input  logic [XLEN-1:0] rs_i,
   output logic [XLEN-1:0] npc_o,
   output logic [XLEN-1:0] link_o
);
   localparam int unsigned EXT_W = XLEN - 18;

   if (XLEN < 29) begin : g_bad_w
      $error("npc_target: XLEN must be at least 29");
   end

   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] br_off;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;
   logic            br_take;

   assign pc_plus4 = pc_i + XLEN'(4);
   assign link_o   = pc_i + XLEN'(8);
   assign br_off   = {{EXT_W{imm_i[15]}}, imm_i, 2'b00};
   assign br_tgt   = pc_plus4 + br_off;
   assign jmp_tgt  = {pc_plus4[XLEN-1:28], jfield_i, 2'b00};

   always_comb begin
      br_take = 1'b0;
      case (flow_i)
         FLOW_BR_EQ: br_take = eq_i;
         FLOW_BR_NE: br_take = ~eq_i;
         default:    br_take = 1'b0;
      endcase
   end

   always_comb begin
      case (flow_i)
         FLOW_JUMP,
         FLOW_JLINK: npc_o = jmp_tgt;
         FLOW_JREG:  npc_o = rs_i;
         FLOW_BR_EQ,
         FLOW_BR_NE: npc_o = br_take ? br_tgt : pc_plus4;
         default:    npc_o = pc_plus4;
      endcase
   end
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
   parameter int unsigned    XLEN      = 32,
   parameter logic [XLEN-1:0] RESET_VEC = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hold_i,
   input  logic            seq_i,
   input  logic [XLEN-1:0] npc_i,
   output logic [XLEN-1:0] pc_o
);
   if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("npc_pcreg: RESET_VEC must be word aligned");
   end

   logic [XLEN-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst)          pc_q <= RESET_VEC;
      else if (!hold_i) pc_q <= npc_i;
   end

   assign pc_o = pc_q;

   p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> pc_q == RESET_VEC);

   p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
      hold_i |=> $stable(pc_q));

   p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!hold_i && seq_i) |=> pc_q == $past(pc_q) + XLEN'(4));
endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit
   import npc_pkg::*;
#(
   parameter int unsigned     XLEN      = 32,
   parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000,
   parameter int unsigned     LINK_REG  = 31,
   parameter bit              XOR_CMP   = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                stall_i,
   input  logic [INSTR_W-1:0]  instr_i,
   input  logic [XLEN-1:0]     rs_val_i,
   input  logic [XLEN-1:0]     rt_val_i,
   output logic [XLEN-1:0]     pc_o,
   output logic [XLEN-1:0]     npc_o,
   output logic                link_we_o,
   output logic [4:0]          link_idx_o,
   output logic [XLEN-1:0]     link_data_o
);
   if (LINK_REG > 31) begin : g_bad_link
      $error("pc_flow_unit: LINK_REG must fit in five bits");
   end

   flow_e       flow;
   logic [15:0] imm;
   logic [25:0] jfield;
   logic        ops_eq;
   logic        is_seq;

   npc_decode u_dec (
      .instr_i  (instr_i),
      .flow_o   (flow),
      .imm_o    (imm),
      .jfield_o (jfield)
   );

   npc_compare #(.XLEN(XLEN), .XOR_CMP(XOR_CMP)) u_cmp (
      .a_i  (rs_val_i),
      .b_i  (rt_val_i),
      .eq_o (ops_eq)
   );

   npc_target #(.XLEN(XLEN)) u_tgt (
      .pc_i     (pc_o),
      .flow_i   (flow),
      .eq_i     (ops_eq),
      .imm_i    (imm),
      .jfield_i (jfield),
      .rs_i     (rs_val_i),
      .npc_o    (npc_o),
      .link_o   (link_data_o)
   );

   assign is_seq = (flow == FLOW_SEQ);

   npc_pcreg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .hold_i (stall_i),
      .seq_i  (is_seq),
      .npc_i  (npc_o),
      .pc_o   (pc_o)
   );

   assign link_we_o  = (flow == FLOW_JLINK) && !stall_i && !rst;
   assign link_idx_o = 5'(LINK_REG);

   p_link_opc_r9: assert property (@(posedge clk) disable iff (rst)
      link_we_o |-> instr_i[31:26] == OPC_JUMPLINK);

   p_link_stall_r2: assert property (@(posedge clk) disable iff (rst)
      stall_i |-> !link_we_o);

   p_jreg_load_r8: assert property (@(posedge clk) disable iff (rst)
      (!stall_i && instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'h08)
      |=> pc_o == $past(rs_val_i));

   p_jump_align_r6: assert property (@(posedge clk) disable iff (rst)
      (!stall_i && (instr_i[31:26] == 6'd2 || instr_i[31:26] == 6'd3))
      |=> pc_o[1:0] == 2'b00);
endmodule

// File: tb/test_pc_flow_unit.sv
module test_pc_flow_unit;
   localparam logic [31:0] RV = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst;
   logic        stall;
   logic [31:0] instr, rs_v, rt_v;
   logic [31:0] pc, npc, ldata;
   logic        lwe;
   logic [4:0]  lidx;
   int          n_vec = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   pc_flow_unit i_pc_flow_unit (
      .clk (clk), .rst (rst), .stall_i (stall), .instr_i (instr),
      .rs_val_i (rs_v), .rt_val_i (rt_v), .pc_o (pc), .npc_o (npc),
      .link_we_o (lwe), .link_idx_o (lidx), .link_data_o (ldata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_imm(input logic [5:0] op, input logic [15:0] imm);
      return {op, 5'd1, 5'd2, imm};
   endfunction

   function automatic logic [31:0] mk_jmp(input logic [5:0] op, input logic [25:0] f);
      return {op, f};
   endfunction

   localparam logic [31:0] JR_INS  = {6'd0, 5'd1, 15'd0, 6'h08};
   localparam logic [31:0] ADD_INS = {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20};

   // drive at falling edge, check link strobe, then one clock edge
   task automatic apply(input string req, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic stl, input logic exp_lwe,
                        input logic [31:0] exp_pc);
      logic [31:0] pc_now;
      instr = ins; rs_v = a; rt_v = b; stall = stl;
      pc_now = pc;
      #1;
      check({req, " link_we"}, {31'd0, lwe}, {31'd0, exp_lwe});
      if (exp_lwe) begin
         check({req, " link_idx"}, {27'd0, lidx}, 32'd31);
         check({req, " link_data"}, ldata, pc_now + 32'd8);
      end
      @(posedge clk); @(negedge clk);
      check({req, " pc"}, pc, exp_pc);
   endtask

   task automatic set_pc(input logic [31:0] v);
      apply("R8 jr", JR_INS, v, 32'h0, 1'b0, 1'b0, v);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] p, e, a, b;
      logic [15:0] imm;
      logic [25:0] f;
      rst = 1'b1; stall = 1'b0; instr = ADD_INS; rs_v = '0; rt_v = '0;
      @(negedge clk); @(negedge clk);
      // R1 / R9: reset vector and no link write in reset
      instr = mk_jmp(6'd3, 26'h1);
      #1;
      check("R9 link_we in reset", {31'd0, lwe}, 32'd0);
      check("R1 reset vector", pc, RV);
      @(negedge clk);
      rst = 1'b0;

      // R3 / R9: non-control opcodes advance by four
      for (int k = 0; k < 8; k++) begin
         p = (32'(k) << 28) | (32'(k) << 8);
         set_pc(p);
         apply("R3 seq", mk_imm(6'(8 + k * 5), 16'(k * 7)), p, p, 1'b0, 1'b0, p + 32'd4);
         apply("R3 rtype", ADD_INS, 32'h5, 32'h5, 1'b0, 1'b0, p + 32'd8);
      end

      // R4 / R5: both conditional branches, taken and not taken
      for (int k = 0; k < 16; k++) begin
         imm = 16'(k * 4369);
         p = 32'h2000_0000 + 32'(k) * 32'h100;
         e = p + 32'd4 + 32'(int'($signed(imm)) * 4);
         a = 32'hA5A5_0000 + 32'(k);
         b = a ^ (32'd1 << (k * 2));
         set_pc(p);
         apply("R4 eq taken",    mk_imm(6'd4, imm), a, a, 1'b0, 1'b0, e);
         set_pc(p);
         apply("R4 eq fall",     mk_imm(6'd4, imm), a, b, 1'b0, 1'b0, p + 32'd4);
         set_pc(p);
         apply("R5 ne taken",    mk_imm(6'd5, imm), a, b, 1'b0, 1'b0, e);
         set_pc(p);
         apply("R5 ne fall",     mk_imm(6'd5, imm), a, a, 1'b0, 1'b0, p + 32'd4);
      end

      // R10: wrap-around
      set_pc(32'hFFFF_FFFC);
      apply("R10 seq wrap", ADD_INS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
      set_pc(32'h0000_0010);
      apply("R10 branch wrap", mk_imm(6'd4, 16'h8000), 32'h3, 32'h3, 1'b0, 1'b0, 32'hFFFE_0014);

      // R6 / R7: region jumps and link
      for (int k = 0; k < 16; k++) begin
         p = (32'(k) << 28) | 32'h0FFF_FFFC;
         f = 26'(k * 32'h0123457);
         e = ((p + 32'd4) & 32'hF000_0000) | (32'(f) << 2);
         set_pc(p);
         apply("R6 jump", mk_jmp(6'd2, f), 32'h0, 32'h0, 1'b0, 1'b0, e);
         set_pc(p);
         apply("R7 jal", mk_jmp(6'd3, f), 32'h0, 32'h0, 1'b0, 1'b1, e);
      end

      // R8: register jump takes the value unchanged
      set_pc(32'h1234_5679);
      set_pc(32'h0000_0000);

      // R2: stall holds PC and blocks link
      set_pc(32'h0000_3000);
      apply("R2 stall jal", mk_jmp(6'd3, 26'h3FF), 32'h0, 32'h0, 1'b1, 1'b0, 32'h0000_3000);
      apply("R2 stall beq", mk_imm(6'd4, 16'h0040), 32'h9, 32'h9, 1'b1, 1'b0, 32'h0000_3000);
      apply("R2 stall jr", JR_INS, 32'h7777_0000, 32'h0, 1'b1, 1'b0, 32'h0000_3000);
      apply("R2 release", ADD_INS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0000_3004);

      // R1: reset in mid-run overrides a pending jump
      rst = 1'b1;
      apply("R1 mid reset", mk_jmp(6'd2, 26'h155), 32'h0, 32'h0, 1'b0, 1'b0, RV);
      rst = 1'b0;
      apply("R3 after reset", ADD_INS, 32'h0, 32'h0, 1'b0, 1'b0, RV + 32'd4);

      finish_run();
   end
endmodule